// File: doc/BRIEF.md
# Long Multiply-Accumulate Datapath

This block multiplies two 32-bit operands and can add the product to a 64-bit accumulator. The accumulator arrives as two 32-bit words, low and high, and the result leaves the same way. An opcode picks the operation. There are plain unsigned and signed long products, and unsigned and signed multiply-accumulate into the concatenated accumulator. One unsigned mode adds the two accumulator words as separate 32-bit addends rather than as one 64-bit value. The remaining modes use signed halfwords: a single halfword product, where each operand's half is chosen on its own, and dual halfword products that are summed or differenced, with an optional swap of the second operand's halves.

A caller presents the operands and pulses `start_i` for one cycle. On the next cycle the result is held in a register and `done_o` pulses. The result stays on the outputs until the next start. Every result wraps modulo 2^64, and the block produces no overflow indication.

Top module: `long_mac`

## Requirements
- R1: While `rst_ni` is low, `lo_o`, `hi_o` and `done_o` are all zero.
- R2: `done_o` is high for exactly the one cycle after a cycle in which `start_i` is high. `lo_o` and `hi_o` change only on that cycle and otherwise keep their previous values.
- R3: Opcode 0 gives the unsigned 64-bit product of `a_i` and `b_i`. The result is split as `lo_o` = bits [31:0] and `hi_o` = bits [63:32].
- R4: Opcode 1 gives the product of `a_i` and `b_i` taken as signed 32-bit values, as a 64-bit two's-complement result.
- R5: Opcode 2 gives the unsigned product plus the accumulator {`hi_i`,`lo_i`}, modulo 2^64.
- R6: Opcode 3 gives the signed product plus the accumulator {`hi_i`,`lo_i`}, modulo 2^64.
- R7: Opcode 4 gives the unsigned product plus `lo_i` plus `hi_i`. Both words are treated as separate zero-extended 32-bit addends.
- R8: Opcode 5 multiplies one signed halfword of `a_i` by one signed halfword of `b_i` and adds the 64-bit accumulator.
  - `a_top_i`=1 selects `a_i`[31:16]; otherwise `a_i`[15:0] is used.
  - `b_top_i` selects the half of `b_i` in the same way.
- R9: Opcode 6 forms the top product a[31:16]·b[31:16] and the bottom product a[15:0]·b[15:0], both signed. It adds both products to the accumulator.
  - `xchg_i`=1 swaps the halves of `b_i` first.
- R10: Opcode 7 forms the same two products, with the same `xchg_i` swap, and gives bottom product minus top product plus the accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to compute |
| op_i | input | 3 | Operation code (0..7) |
| a_i | input | 32 | First multiplicand |
| b_i | input | 32 | Second multiplicand |
| lo_i | input | 32 | Accumulator low word / first addend |
| hi_i | input | 32 | Accumulator high word / second addend |
| a_top_i | input | 1 | Halfword mode: use upper half of `a_i` |
| b_top_i | input | 1 | Halfword mode: use upper half of `b_i` |
| xchg_i | input | 1 | Dual modes: swap the halves of `b_i` |
| lo_o | output | 32 | Result bits [31:0] |
| hi_o | output | 32 | Result bits [63:32] |
| done_o | output | 1 | Result valid pulse |

## Verification
The assertions assume that all operands are sampled in the same cycle as `start_i`, and that `op_i` is never X while `start_i` is high. Their arithmetic properties use a zero operand as a fixed point, so that the expected value is just the accumulator or the sum of the addends. The bench presents every input for exactly one cycle with `start_i`, then drops the strobe. It sweeps all eight opcodes and all select combinations over a grid of signed and unsigned corner values, so every assertion precondition is reached with legal inputs.

// File: rtl/lmac_pkg.sv
package lmac_pkg;
  typedef enum logic [2:0] {
    OP_UMUL  = 3'd0,
    OP_SMUL  = 3'd1,
    OP_UMAC  = 3'd2,
    OP_SMAC  = 3'd3,
    OP_UDACC = 3'd4,
    OP_HMAC  = 3'd5,
    OP_DADD  = 3'd6,
    OP_DSUB  = 3'd7
  } lmac_op_e;

  function automatic logic op_is_signed_wide(lmac_op_e op);
    return (op == OP_SMUL) || (op == OP_SMAC);
  endfunction
endpackage

// File: rtl/lmac_wide_mul.sv
module lmac_wide_mul #(
  parameter int DW = 32,
  localparam int RW = 2 * DW
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sgn_i,
  output logic [RW-1:0] prod_o
);
  logic [RW-1:0] a_ext, b_ext;

  // sign or zero extension to full width; low RW bits of product are exact
  assign a_ext  = {{DW{sgn_i & a_i[DW-1]}}, a_i};
  assign b_ext  = {{DW{sgn_i & b_i[DW-1]}}, b_i};
  assign prod_o = a_ext * b_ext;
endmodule

// File: rtl/lmac_half_lanes.sv
module lmac_half_lanes
  import lmac_pkg::*;
#(
  parameter int DW = 32,
  localparam int HW = DW / 2,
  localparam int NL = 2
) (
  input  lmac_op_e      op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          a_top_i,
  input  logic          b_top_i,
  input  logic          xchg_i,
  output logic [DW-1:0] prod_top_o,
  output logic [DW-1:0] prod_bot_o
);
  logic [HW-1:0] a_hi, a_lo, b_hi, b_lo;
  logic [HW-1:0] ah [NL];
  logic [HW-1:0] bh [NL];
  logic [DW-1:0] prod [NL];

  assign a_hi = a_i[DW-1:HW];
  assign a_lo = a_i[HW-1:0];
  assign b_hi = b_i[DW-1:HW];
  assign b_lo = b_i[HW-1:0];

  // lane 0 = top lane (also serves single-halfword mode), lane 1 = bottom lane
  always_comb begin
    if (op_i == OP_HMAC) begin
      ah[0] = a_top_i ? a_hi : a_lo;
      bh[0] = b_top_i ? b_hi : b_lo;
    end else begin
      ah[0] = a_hi;
      bh[0] = xchg_i ? b_lo : b_hi;
    end
    ah[1] = a_lo;
    bh[1] = xchg_i ? b_hi : b_lo;
  end

  for (genvar k = 0; k < NL; k++) begin : g_lane
    logic [DW-1:0] ax, bx;
    assign ax      = {{HW{ah[k][HW-1]}}, ah[k]};
    assign bx      = {{HW{bh[k][HW-1]}}, bh[k]};
    assign prod[k] = ax * bx;
  end

  assign prod_top_o = prod[0];
  assign prod_bot_o = prod[1];
endmodule

// File: rtl/lmac_combine.sv
module lmac_combine
  import lmac_pkg::*;
#(
  parameter int DW = 32,
  localparam int RW = 2 * DW
) (
  input  lmac_op_e      op_i,
  input  logic [RW-1:0] wide_i,
  input  logic [DW-1:0] prod_top_i,
  input  logic [DW-1:0] prod_bot_i,
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  output logic [RW-1:0] res_o
);
  logic [RW-1:0] acc, dacc, ext_t, ext_b;

  assign acc   = {hi_i, lo_i};
  assign dacc  = {{DW{1'b0}}, lo_i} + {{DW{1'b0}}, hi_i};
  assign ext_t = {{DW{prod_top_i[DW-1]}}, prod_top_i};
  assign ext_b = {{DW{prod_bot_i[DW-1]}}, prod_bot_i};

  always_comb begin
    unique case (op_i)
      OP_UMUL, OP_SMUL: res_o = wide_i;
      OP_UMAC, OP_SMAC: res_o = wide_i + acc;
      OP_UDACC:         res_o = wide_i + dacc;
      OP_HMAC:          res_o = ext_t + acc;
      OP_DADD:          res_o = ext_t + ext_b + acc;
      OP_DSUB:          res_o = ext_b - ext_t + acc;
      default:          res_o = '0;
    endcase
  end
endmodule

// File: rtl/long_mac.sv
module long_mac
  import lmac_pkg::*;
#(
  parameter int DW = 32,
  localparam int RW = 2 * DW,
  localparam int OW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [OW-1:0] op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  input  logic          a_top_i,
  input  logic          b_top_i,
  input  logic          xchg_i,
  output logic [DW-1:0] lo_o,
  output logic [DW-1:0] hi_o,
  output logic          done_o
);
  lmac_op_e      op;
  logic [RW-1:0] wide, res_d, res_q;
  logic [DW-1:0] p_top, p_bot;
  logic          done_q;

  assign op = lmac_op_e'(op_i);

  lmac_wide_mul #(.DW(DW)) u_wide (
    .a_i   (a_i),
    .b_i   (b_i),
    .sgn_i (op_is_signed_wide(op)),
    .prod_o(wide)
  );

  lmac_half_lanes #(.DW(DW)) u_half (
    .op_i      (op),
    .a_i       (a_i),
    .b_i       (b_i),
    .a_top_i   (a_top_i),
    .b_top_i   (b_top_i),
    .xchg_i    (xchg_i),
    .prod_top_o(p_top),
    .prod_bot_o(p_bot)
  );

  lmac_combine #(.DW(DW)) u_comb (
    .op_i      (op),
    .wide_i    (wide),
    .prod_top_i(p_top),
    .prod_bot_i(p_bot),
    .lo_i      (lo_i),
    .hi_i      (hi_i),
    .res_o     (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= start_i;
      if (start_i) res_q <= res_d;
    end
  end

  assign lo_o   = res_q[DW-1:0];
  assign hi_o   = res_q[RW-1:DW];
  assign done_o = done_q;
endmodule

// File: rtl/long_mac_checker.sv
module long_mac_checker #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [2:0]    op_i,
  input logic [DW-1:0] a_i,
  input logic [DW-1:0] b_i,
  input logic [DW-1:0] lo_i,
  input logic [DW-1:0] hi_i,
  input logic [DW-1:0] lo_o,
  input logic [DW-1:0] hi_o,
  input logic          done_o
);
  always_comb begin
    if (!rst_ni) AST_RESET_CLEAR: assert (lo_o == '0 && hi_o == '0 && !done_o); // R1
  end

  AST_DONE_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o); // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o); // R2
  AST_RESULT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(lo_o) && $stable(hi_o))); // R2
  AST_UMUL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 3'd0 && b_i == '0) |=> (lo_o == '0 && hi_o == '0)); // R3
  AST_UMAC_ZERO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 3'd2 && a_i == '0) |=> (lo_o == $past(lo_i) && hi_o == $past(hi_i))); // R5
  AST_DACC_SPLIT_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 3'd4 && a_i == '0) |=>
      ({hi_o, lo_o} == ({{DW{1'b0}}, $past(lo_i)} + {{DW{1'b0}}, $past(hi_i)}))); // R7
  AST_HMAC_ZERO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 3'd5 && b_i == '0) |=> (lo_o == $past(lo_i) && hi_o == $past(hi_i))); // R8
  AST_DSUB_ZERO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 3'd7 && a_i == '0) |=> (lo_o == $past(lo_i) && hi_o == $past(hi_i))); // R10
endmodule

bind long_mac long_mac_checker #(.DW(DW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .op_i   (op_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .lo_i   (lo_i),
  .hi_i   (hi_i),
  .lo_o   (lo_o),
  .hi_o   (hi_o),
  .done_o (done_o)
);

// File: tb/long_mac_bench.sv
`timescale 1ns/1ps
module long_mac_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] a = '0, b = '0, lo = '0, hi = '0;
  logic        at = 1'b0, bt = 1'b0, xc = 1'b0;
  logic [31:0] lo_q, hi_q;
  logic        done_q;
  int          n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  long_mac u_long_mac (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .a_i(a), .b_i(b), .lo_i(lo), .hi_i(hi),
    .a_top_i(at), .b_top_i(bt), .xchg_i(xc),
    .lo_o(lo_q), .hi_o(hi_q), .done_o(done_q)
  );

  function automatic logic [31:0] corner(int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h7FFF_FFFF;
      5: return 32'h8000_7FFF;
      6: return 32'h1234_ABCD;
      default: return 32'hFFFF_8000;
    endcase
  endfunction

  function automatic logic [63:0] sx32(logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] sx16(logic [15:0] v);
    return {{48{v[15]}}, v};
  endfunction

  function automatic logic [63:0] model(logic [2:0] o, logic [31:0] x, logic [31:0] y,
                                        logic [31:0] l, logic [31:0] h,
                                        logic t1, logic t2, logic sw);
    logic [63:0] acc, pt, pb;
    logic [15:0] yt, yb;
    acc = {h, l};
    yt  = sw ? y[15:0]  : y[31:16];
    yb  = sw ? y[31:16] : y[15:0];
    pt  = sx16(x[31:16]) * sx16(yt);
    pb  = sx16(x[15:0])  * sx16(yb);
    case (o)
      3'd0: return {32'b0, x} * {32'b0, y};
      3'd1: return sx32(x) * sx32(y);
      3'd2: return {32'b0, x} * {32'b0, y} + acc;
      3'd3: return sx32(x) * sx32(y) + acc;
      3'd4: return {32'b0, x} * {32'b0, y} + {32'b0, l} + {32'b0, h};
      3'd5: return sx16(t1 ? x[31:16] : x[15:0]) * sx16(t2 ? y[31:16] : y[15:0]) + acc;
      3'd6: return pt + pb + acc;
      default: return pb - pt + acc;
    endcase
  endfunction

  function automatic string req_of(logic [2:0] o);
    case (o)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_one(logic [2:0] o, logic [31:0] x, logic [31:0] y,
                         logic [31:0] l, logic [31:0] h, logic t1, logic t2, logic sw,
                         bit check_hold);
    logic [63:0] exp;
    @(negedge clk);
    op = o; a = x; b = y; lo = l; hi = h; at = t1; bt = t2; xc = sw; start = 1'b1;
    exp = model(o, x, y, l, h, t1, t2, sw);
    @(negedge clk);
    start = 1'b0;
    a = ~x; b = ~y; lo = ~l; hi = ~h;
    check64("R2", {63'b0, done_q}, 64'd1);
    check64(req_of(o), {hi_q, lo_q}, exp);
    if (check_hold) begin
      @(negedge clk);
      check64("R2", {63'b0, done_q}, 64'd0);
      check64("R2", {hi_q, lo_q}, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #3;
    // R1: outputs cleared while reset is held
    check64("R1", {hi_q, lo_q}, 64'd0);
    check64("R1", {63'b0, done_q}, 64'd0);
    repeat (3) @(negedge clk);
    check64("R1", {hi_q, lo_q}, 64'd0);
    rst_n = 1'b1;

    // sweep: every opcode, selector combination and corner grid
    for (int o = 0; o < 8; o++) begin
      for (int s = 0; s < 8; s++) begin
        for (int i = 0; i < 8; i++) begin
          for (int j = 0; j < 8; j++) begin
            run_one(3'(o), corner(i), corner(j), corner((i + j + s) % 8),
                    corner((i + 3 * j + o) % 8), s[0], s[1], s[2], (j == 3));
          end
        end
      end
    end

    // wrap-around: R5 all-ones operands and accumulator
    run_one(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b1);
    // R6 most negative squared plus negative accumulator
    run_one(3'd3, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 1'b1);
    // R10 bottom minus top, distinct halves
    run_one(3'd7, 32'h0003_0005, 32'h0007_000B, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    check64("R10", {hi_q, lo_q}, 64'd34);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule